// File: doc/BRIEF.md
# DSI Video-Mode Packet Sequencer

This block walks through one video frame line by line and, for each line, issues the ordered list of packet requests a DSI link layer needs: sync markers, blanking fillers, the pixel stream packet, optional null padding and an end-of-transmission marker. Each request is a descriptor made of a data identifier byte, a 16-bit word count and a flag that marks the packet whose payload is pixel data. Descriptors leave through a valid/ready handshake. The downstream packet builder adds header ECC and payload CRC, fetches the pixels and spreads bytes over the lanes; none of that is done here.

Horizontal region lengths are programmed in byte periods and vertical regions in lines. Mode inputs select the virtual channel, the pixel format, sync-pulse or sync-event signalling, burst or null-padded fill, horizontal sync-end on blank lines, suppression of each horizontal blanking region, a vertical count that uses only the active and front porch lines, and suppression of the end-of-transmission packet. All timing and mode inputs are captured when a frame begins, so edits made mid-frame take effect on the next frame. While `enable` stays high frames follow back to back. When it is low at the end of a frame, the sequencer goes idle.

Top module: `dsi_vid_seq`

## Requirements
- R1: After reset, and while `enable` is low, `pkt_valid` is low. The first descriptor after `enable` rises opens a new frame.
- R2: `pkt_di` carries the virtual channel in bits [7:6] and the data type in bits [5:0]. The pixel packet data type follows `pix_fmt`: 0 gives 0x0E (16-bit), 1 gives 0x1E (18-bit packed), 2 gives 0x2E (18-bit in three bytes), 3 gives 0x3E (24-bit). Its word count is `act_bytes` and `pkt_pixel` is 1 on it alone.
- R3: In sync-pulse mode (`sync_pulse`=1) an active line is: start marker, HSA blanking, HSYNC end (0x31), HBP blanking, pixels. In sync-event mode there is no HSA blanking and no HSYNC end, and the HBP blanking covers `hsa_bytes`+`hbp_bytes`.
- R4: A blanking (0x19) or null (0x09) packet has word count equal to its region length in bytes minus 6, and 0 when the length is 6 or less.
- R5: The vertical order is VSA, VBP, active, VFP lines. Line 0 starts with VSYNC start (0x01). In sync-pulse mode with a nonzero VSA, the first line after VSA starts with VSYNC end (0x11). Every other line starts with HSYNC start (0x21). All short packets have word count 0.
- R6: In sync-pulse mode with `hse`=1, blank lines also carry HSA blanking and HSYNC end after the start marker. With `hse`=0 they carry the start marker only (plus EoT).
- R7: `skip_hsa`, `skip_hbp` and `skip_hfp` each remove their blanking packet from every line.
- R8: With `burst`=0 and nonzero `null_bytes`, each active line has a null packet right after the pixel packet. With `burst`=1 no null packet is ever sent.
- R9: Each line ends with an EoT packet (0x08) unless `eot_dis` is 1, in which case none is sent. On active lines the HFP blanking precedes it.
- R10: With `auto_vcnt`=1 the VSA and VBP counts are ignored: the frame is `vact_lines` active lines then `vfp_lines` porch lines, and no VSYNC end is sent.
- R11: While `pkt_valid` is high and `pkt_ready` is low, all descriptor outputs hold steady.
- R12: Inputs are captured only when a frame starts. A change made mid-frame shows from the next frame on. Frames repeat while `enable` is high, and the sequencer stops after the frame in progress when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frames while high |
| vc | input | 2 | Virtual channel |
| pix_fmt | input | 2 | Pixel format select |
| sync_pulse | input | 1 | 1 = sync-pulse, 0 = sync-event signalling |
| burst | input | 1 | 1 = burst fill, 0 = null padding |
| hse | input | 1 | HSYNC end on blank lines |
| skip_hsa | input | 1 | Suppress HSA blanking |
| skip_hbp | input | 1 | Suppress HBP blanking |
| skip_hfp | input | 1 | Suppress HFP blanking |
| auto_vcnt | input | 1 | Ignore VSA and VBP counts |
| eot_dis | input | 1 | Suppress EoT packets |
| hsa_bytes | input | 16 | HSA length in bytes |
| hbp_bytes | input | 16 | HBP length in bytes |
| hfp_bytes | input | 16 | HFP length in bytes |
| act_bytes | input | 16 | Pixel payload per line in bytes |
| null_bytes | input | 16 | Null padding length in bytes (non-burst) |
| vsa_lines | input | 12 | VSA line count |
| vbp_lines | input | 12 | VBP line count |
| vact_lines | input | 12 | Active line count |
| vfp_lines | input | 12 | VFP line count |
| pkt_ready | input | 1 | Consumer accepts descriptor |
| pkt_valid | output | 1 | Descriptor available |
| pkt_di | output | 8 | Data identifier |
| pkt_wc | output | 16 | Word count |
| pkt_pixel | output | 1 | Descriptor is the pixel payload packet |

## Verification
The assertions assume that timing and mode inputs are meaningful only when a frame is captured, and that `pkt_ready` may drop at any cycle. They also assume a frame has at least one line. The bench programs every scenario with nonzero line totals. It changes configuration only while a frame is in progress, to exercise capture at frame start. It stalls `pkt_ready` on a fixed pattern so that descriptors are held across several cycles, and it compares each accepted descriptor against a frame list it builds itself from the mode rules.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_NULL  = 6'h09;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_EOT   = 6'h08;
  localparam int unsigned PKT_OVERHEAD = 6;

  // packet slots within a line, in transmit order
  typedef enum logic [2:0] {
    ST_START, ST_HSA, ST_HSE, ST_HBP, ST_PIX, ST_NULL, ST_HFP, ST_EOT
  } step_t;

  typedef struct packed {
    logic [1:0] vc;
    logic [1:0] fmt;
    logic       sync_pulse;
    logic       burst;
    logic       hse;
    logic       skip_hsa;
    logic       skip_hbp;
    logic       skip_hfp;
    logic       auto_vcnt;
    logic       eot_dis;
  } mode_t;

  function automatic logic [5:0] pix_dt(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 6'h0E;
      2'd1:    return 6'h1E;
      2'd2:    return 6'h2E;
      default: return 6'h3E;
    endcase
  endfunction

  function automatic logic [31:0] blank_wc(input logic [31:0] len);
    return (len > PKT_OVERHEAD) ? len - PKT_OVERHEAD : 32'd0;
  endfunction

  // is slot s present on a line of this kind
  function automatic logic step_on(input step_t s, input mode_t m,
                                   input logic act, input logic has_null);
    case (s)
      ST_START: return 1'b1;
      ST_HSA:   return m.sync_pulse && !m.skip_hsa && (act || m.hse);
      ST_HSE:   return m.sync_pulse && (act || m.hse);
      ST_HBP:   return act && !m.skip_hbp;
      ST_PIX:   return act;
      ST_NULL:  return act && !m.burst && has_null;
      ST_HFP:   return act && !m.skip_hfp;
      default:  return !m.eot_dis;
    endcase
  endfunction

endpackage

// File: rtl/dsi_vregion.sv
module dsi_vregion #(
  parameter int LIN_W = 12
) (
  input  logic [LIN_W+1:0] line,
  input  logic [LIN_W-1:0] vsa,
  input  logic [LIN_W-1:0] vbp,
  input  logic [LIN_W-1:0] vact,
  input  logic [LIN_W-1:0] vfp,
  input  logic             auto_vcnt,
  output logic             active,
  output logic             last_line,
  output logic             vse_line
);
  localparam int SW = LIN_W + 2;

  logic [SW-1:0] vsa_e, vbp_e, act_lo, act_hi, total;

  always_comb begin
    vsa_e  = auto_vcnt ? '0 : SW'(vsa);
    vbp_e  = auto_vcnt ? '0 : SW'(vbp);
    act_lo = vsa_e + vbp_e;
    act_hi = act_lo + SW'(vact);
    total  = act_hi + SW'(vfp);
  end

  assign active    = (line >= act_lo) && (line < act_hi);
  assign last_line = (total == '0) ? (line == '0) : (line == total - 1'b1);
  assign vse_line  = (vsa_e != '0) && (line == vsa_e);

endmodule

// File: rtl/dsi_step_pick.sv
module dsi_step_pick
  import dsi_seq_pkg::*;
(
  input  step_t cur,
  input  mode_t mode,
  input  logic  act,
  input  logic  has_null,
  output step_t nxt,
  output logic  line_end
);
  // lowest present slot above the current one wins
  always_comb begin
    nxt      = ST_EOT;
    line_end = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (i > int'(cur) && step_on(step_t'(3'(i)), mode, act, has_null)) begin
        nxt      = step_t'(3'(i));
        line_end = 1'b0;
      end
    end
  end

endmodule

// File: rtl/dsi_vid_seq.sv
module dsi_vid_seq
  import dsi_seq_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       vc,
  input  logic [1:0]       pix_fmt,
  input  logic             sync_pulse,
  input  logic             burst,
  input  logic             hse,
  input  logic             skip_hsa,
  input  logic             skip_hbp,
  input  logic             skip_hfp,
  input  logic             auto_vcnt,
  input  logic             eot_dis,
  input  logic [LEN_W-1:0] hsa_bytes,
  input  logic [LEN_W-1:0] hbp_bytes,
  input  logic [LEN_W-1:0] hfp_bytes,
  input  logic [LEN_W-1:0] act_bytes,
  input  logic [LEN_W-1:0] null_bytes,
  input  logic [LIN_W-1:0] vsa_lines,
  input  logic [LIN_W-1:0] vbp_lines,
  input  logic [LIN_W-1:0] vact_lines,
  input  logic [LIN_W-1:0] vfp_lines,
  input  logic             pkt_ready,
  output logic             pkt_valid,
  output logic [7:0]       pkt_di,
  output logic [LEN_W-1:0] pkt_wc,
  output logic             pkt_pixel
);
  localparam logic [31:0] WC_MAX = 32'((64'd1 << LEN_W) - 1);

  function automatic logic [LEN_W-1:0] clamp_wc(input logic [31:0] v);
    return (v > WC_MAX) ? WC_MAX[LEN_W-1:0] : v[LEN_W-1:0];
  endfunction

  mode_t            mode_q;
  logic [LEN_W-1:0] hsa_q, hbp_q, hfp_q, act_q, null_q;
  logic [LIN_W-1:0] vsa_q, vbp_q, vact_q, vfp_q;
  logic             running;
  logic [LIN_W+1:0] line_q;
  step_t            step_q, nxt_step;

  // named events for the assertions
  logic fire, line_end, last_line, frame_done, load_cfg;
  logic active, vse_line;

  dsi_vregion #(.LIN_W(LIN_W)) u_vregion (
    .line(line_q), .vsa(vsa_q), .vbp(vbp_q), .vact(vact_q), .vfp(vfp_q),
    .auto_vcnt(mode_q.auto_vcnt), .active(active), .last_line(last_line),
    .vse_line(vse_line)
  );

  dsi_step_pick u_pick (
    .cur(step_q), .mode(mode_q), .act(active), .has_null(null_q != '0),
    .nxt(nxt_step), .line_end(line_end)
  );

  assign fire       = pkt_valid && pkt_ready;
  assign frame_done = fire && line_end && last_line;
  assign load_cfg   = enable && (!running || frame_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      hsa_q   <= '0; hbp_q <= '0; hfp_q <= '0; act_q <= '0; null_q <= '0;
      vsa_q   <= '0; vbp_q <= '0; vact_q <= '0; vfp_q <= '0;
      running <= 1'b0;
      line_q  <= '0;
      step_q  <= ST_START;
    end else begin
      if (load_cfg) begin
        mode_q <= '{vc: vc, fmt: pix_fmt, sync_pulse: sync_pulse, burst: burst,
                    hse: hse, skip_hsa: skip_hsa, skip_hbp: skip_hbp,
                    skip_hfp: skip_hfp, auto_vcnt: auto_vcnt, eot_dis: eot_dis};
        hsa_q  <= hsa_bytes;  hbp_q <= hbp_bytes; hfp_q <= hfp_bytes;
        act_q  <= act_bytes;  null_q <= null_bytes;
        vsa_q  <= vsa_lines;  vbp_q <= vbp_lines;
        vact_q <= vact_lines; vfp_q <= vfp_lines;
        running <= 1'b1;
        line_q  <= '0;
        step_q  <= ST_START;
      end else if (fire) begin
        if (frame_done) begin
          running <= 1'b0;
          line_q  <= '0;
          step_q  <= ST_START;
        end else if (line_end) begin
          line_q <= line_q + 1'b1;
          step_q <= ST_START;
        end else begin
          step_q <= nxt_step;
        end
      end
    end
  end

  // descriptor for the current slot
  logic [5:0]  dt;
  logic [31:0] wc_raw;
  logic        pix;

  always_comb begin
    dt     = DT_HSS;
    wc_raw = '0;
    pix    = 1'b0;
    case (step_q)
      ST_START: dt = (line_q == '0) ? DT_VSS :
                     (mode_q.sync_pulse && vse_line) ? DT_VSE : DT_HSS;
      ST_HSA: begin dt = DT_BLANK; wc_raw = blank_wc(32'(hsa_q)); end
      ST_HSE: dt = DT_HSE;
      ST_HBP: begin
        dt     = DT_BLANK;
        wc_raw = mode_q.sync_pulse ? blank_wc(32'(hbp_q))
                                   : blank_wc(32'(hsa_q) + 32'(hbp_q));
      end
      ST_PIX: begin dt = pix_dt(mode_q.fmt); wc_raw = 32'(act_q); pix = 1'b1; end
      ST_NULL: begin dt = DT_NULL; wc_raw = blank_wc(32'(null_q)); end
      ST_HFP: begin dt = DT_BLANK; wc_raw = blank_wc(32'(hfp_q)); end
      default: dt = DT_EOT;
    endcase
  end

  assign pkt_valid = running;
  assign pkt_di    = {mode_q.vc, dt};
  assign pkt_wc    = clamp_wc(wc_raw);
  assign pkt_pixel = pix;

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_di) && $stable(pkt_wc)
                                && $stable(pkt_pixel));
  // R12
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && enable |=> pkt_valid && pkt_di[5:0] == DT_VSS);
  // R8
  burst_no_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && mode_q.burst |-> pkt_di[5:0] != DT_NULL);
  // R9
  eot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && mode_q.eot_dis |-> pkt_di[5:0] != DT_EOT);
  // R2
  pixel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_pixel |-> pkt_di[3:0] == 4'hE);
  // R3
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !line_end |=> step_q > $past(step_q));
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !enable |=> !pkt_valid);

endmodule

// File: tb/test_dsi_vid_seq.sv
module test_dsi_vid_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] vc = '0, pix_fmt = '0;
  logic sync_pulse = 0, burst = 0, hse = 0, skip_hsa = 0, skip_hbp = 0;
  logic skip_hfp = 0, auto_vcnt = 0, eot_dis = 0;
  logic [15:0] hsa_bytes = '0, hbp_bytes = '0, hfp_bytes = '0;
  logic [15:0] act_bytes = '0, null_bytes = '0;
  logic [11:0] vsa_lines = '0, vbp_lines = '0, vact_lines = '0, vfp_lines = '0;
  logic pkt_ready = 1'b0;
  logic pkt_valid, pkt_pixel;
  logic [7:0] pkt_di;
  logic [15:0] pkt_wc;

  int n_chk = 0, n_fail = 0;
  int exp_n;
  logic [7:0]  exp_di  [0:255];
  logic [15:0] exp_wc  [0:255];
  logic        exp_pix [0:255];

  always #10 clk = ~clk;

  dsi_vid_seq i_dsi_vid_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vc(vc), .pix_fmt(pix_fmt),
    .sync_pulse(sync_pulse), .burst(burst), .hse(hse), .skip_hsa(skip_hsa),
    .skip_hbp(skip_hbp), .skip_hfp(skip_hfp), .auto_vcnt(auto_vcnt),
    .eot_dis(eot_dis), .hsa_bytes(hsa_bytes), .hbp_bytes(hbp_bytes),
    .hfp_bytes(hfp_bytes), .act_bytes(act_bytes), .null_bytes(null_bytes),
    .vsa_lines(vsa_lines), .vbp_lines(vbp_lines), .vact_lines(vact_lines),
    .vfp_lines(vfp_lines), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
    .pkt_di(pkt_di), .pkt_wc(pkt_wc), .pkt_pixel(pkt_pixel)
  );

  function automatic int ovh(input int len);
    return (len > 6) ? len - 6 : 0;
  endfunction

  task automatic push(input int dt, input int wc, input bit pix);
    exp_di[exp_n]  = {vc, 6'(dt)};
    exp_wc[exp_n]  = 16'(wc);
    exp_pix[exp_n] = pix;
    exp_n++;
  endtask

  // independent frame model from the requirements
  task automatic build_exp();
    int a = auto_vcnt ? 0 : int'(vsa_lines);
    int b = auto_vcnt ? 0 : int'(vbp_lines);
    int lo = a + b;
    int hi = lo + int'(vact_lines);
    int tot = hi + int'(vfp_lines);
    int pdt;
    exp_n = 0;
    case (pix_fmt)
      2'd0: pdt = 'h0E; 2'd1: pdt = 'h1E; 2'd2: pdt = 'h2E; default: pdt = 'h3E;
    endcase
    for (int l = 0; l < tot; l++) begin
      bit act = (l >= lo) && (l < hi);
      if (l == 0) push('h01, 0, 0);
      else if (sync_pulse && a > 0 && l == a) push('h11, 0, 0);
      else push('h21, 0, 0);
      if (sync_pulse && (act || hse)) begin
        if (!skip_hsa) push('h19, ovh(int'(hsa_bytes)), 0);
        push('h31, 0, 0);
      end
      if (act) begin
        if (!skip_hbp)
          push('h19, sync_pulse ? ovh(int'(hbp_bytes))
                                : ovh(int'(hsa_bytes) + int'(hbp_bytes)), 0);
        push(pdt, int'(act_bytes), 1);
        if (!burst && null_bytes != 0) push('h09, ovh(int'(null_bytes)), 0);
        if (!skip_hfp) push('h19, ovh(int'(hfp_bytes)), 0);
      end
      if (!eot_dis) push('h08, 0, 0);
    end
  endtask

  task automatic check(input string tag, input bit ok, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // accept descriptors from..to-1 and compare; optional stall pattern
  task automatic collect(input int from, input int to, input string tag, input bit bp);
    int idx = from;
    int cyc = 0;
    bit stalled = 0;
    logic [7:0] hd; logic [15:0] hw; logic hp;
    while (idx < to && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (stalled)
        check("R11", pkt_valid && pkt_di == hd && pkt_wc == hw && pkt_pixel == hp,
              $sformatf("held di=%h wc=%0d pix=%0d got di=%h wc=%0d pix=%0d v=%0d",
                        hd, hw, hp, pkt_di, pkt_wc, pkt_pixel, pkt_valid));
      pkt_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      #1;
      stalled = 0;
      if (pkt_valid && pkt_ready) begin
        check(tag, pkt_di == exp_di[idx] && pkt_wc == exp_wc[idx] &&
                   pkt_pixel == exp_pix[idx],
              $sformatf("pkt %0d got di=%h wc=%0d pix=%0d expected di=%h wc=%0d pix=%0d",
                        idx, pkt_di, pkt_wc, pkt_pixel, exp_di[idx], exp_wc[idx],
                        exp_pix[idx]));
        idx++;
      end else if (pkt_valid) begin
        stalled = 1; hd = pkt_di; hw = pkt_wc; hp = pkt_pixel;
      end
    end
    check(tag, idx >= to, $sformatf("only %0d of %0d packets seen, expected %0d",
                                    idx, to, to));
    @(posedge clk);
    #1 pkt_ready = 1'b0;
  endtask

  task automatic do_reset();
    enable = 0; pkt_ready = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic base_cfg();
    vc = 2'd1; pix_fmt = 2'd3; sync_pulse = 1; burst = 0; hse = 0;
    skip_hsa = 0; skip_hbp = 0; skip_hfp = 0; auto_vcnt = 0; eot_dis = 0;
    hsa_bytes = 16'd20; hbp_bytes = 16'd40; hfp_bytes = 16'd30;
    act_bytes = 16'd1440; null_bytes = 16'd50;
    vsa_lines = 12'd2; vbp_lines = 12'd1; vact_lines = 12'd2; vfp_lines = 12'd1;
  endtask

  task automatic run_frame(input string tag, input bit bp);
    do_reset();
    build_exp();
    #1 enable = 1;
    collect(0, exp_n, tag, bp);
    enable = 0;
    repeat (2 * exp_n + 4) @(posedge clk);
  endtask

  task automatic t_reset();
    base_cfg();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", pkt_valid == 0, $sformatf("valid=%0d expected 0", pkt_valid));
    end
  endtask

  task automatic t_sync_pulse();
    base_cfg();
    run_frame("R3 R5 R2 sync-pulse frame", 1);
  endtask

  task automatic t_sync_event_burst();
    base_cfg();
    sync_pulse = 0; burst = 1; hse = 1; vc = 2'd2; pix_fmt = 2'd0;
    run_frame("R3 R8 sync-event burst frame", 0);
  endtask

  task automatic t_hse();
    base_cfg();
    hse = 1; pix_fmt = 2'd1; vc = 2'd3;
    run_frame("R6 hse blank lines", 1);
  endtask

  task automatic t_skip();
    base_cfg();
    skip_hsa = 1; skip_hbp = 1; skip_hfp = 1; eot_dis = 1; hse = 1;
    run_frame("R7 R9 skips and no EoT", 0);
  endtask

  task automatic t_short();
    base_cfg();
    hsa_bytes = 16'd3; hbp_bytes = 16'd6; hfp_bytes = 16'd7; null_bytes = 16'd2;
    pix_fmt = 2'd2; vc = 2'd0;
    run_frame("R4 short regions", 0);
  endtask

  task automatic t_auto();
    base_cfg();
    auto_vcnt = 1; vsa_lines = 12'd5; vbp_lines = 12'd4; vact_lines = 12'd3;
    run_frame("R10 auto vertical count", 1);
  endtask

  task automatic t_midframe();
    base_cfg();
    do_reset();
    build_exp();
    #1 enable = 1;
    collect(0, 5, "R12 frame A head", 0);
    // edit inputs while frame A is in progress
    vc = 2'd3; pix_fmt = 2'd0; burst = 1; hsa_bytes = 16'd100; vact_lines = 12'd1;
    hse = 1;
    collect(5, exp_n, "R12 frame A keeps old settings", 1);
    build_exp();
    collect(0, 1, "R12 frame B first packet", 0);
    enable = 0;
    collect(1, exp_n, "R12 frame B new settings", 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pkt_ready = 1;
      check("R12", pkt_valid == 0, $sformatf("valid=%0d after stop expected 0",
                                             pkt_valid));
    end
    pkt_ready = 0;
  endtask

  initial begin
    t_reset();
    t_sync_pulse();
    t_sync_event_burst();
    t_hse();
    t_skip();
    t_short();
    t_auto();
    t_midframe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule